// File: doc/BRIEF.md
# Frame Pulse Format Detector and Converter

This block sits on the frame clock of a 2048 kbit/s serial TDM bus. The bus runs at 32 channels of 8 bits, with two clocks per bit from a 4.096 MHz clock. The block watches the incoming 8 kHz frame pulse and works out which of two common framing styles it carries. The first style idles high and drops low for one clock that straddles the frame boundary. The second style idles low and rises for one clock at the start of channel 5. The block keeps a frame position counter and reloads it from each detected pulse, so the channel and bit counts it reports always line up with the bus.

The block also sends out a frame pulse in the other style, moved by a whole number of channels. One device can therefore sit between a bus of each style and pass framing from one to the other. The counter runs freely between pulses. A frame with no input pulse still produces an output pulse.

Top module: `fp_converter`

## Requirements
- R1: After reset, the channel count reads 0, the bit count reads 0 and `fp_out` is low. The block starts out assuming the idle-high input style until a run of idle samples says otherwise.
- R2: With no pulse detected, the frame position rises by one each clock and wraps from 511 to 0. The bit count is position bits [3:1] and the channel count is position bits [8:4].
- R3: The input style is decided once `fp_in` has been sampled at the same level on 5 consecutive clocks. A high run selects the idle-high style and a low run selects the idle-low style. Until the first decision, no input pulse reloads the counter.
- R4: In the idle-high style, the first clock that samples `fp_in` low after a high sample reloads the position to 0. The clock after that sample therefore shows channel 0, bit 0.
- R5: In the idle-low style, the first clock that samples `fp_in` high after a low sample reloads the position to 80. The clock after that sample therefore shows channel 5, bit 0.
- R6: While the input is in the idle-high style, `fp_out` idles low. It goes high for exactly one clock, the clock in which the position is 79. That clock falls 5 channels (80 clocks) after the input pulse sample.
- R7: While the input is in the idle-low style, `fp_out` idles high. It goes low for exactly one clock, the clock in which the position is 511. That clock falls 27 channels (432 clocks) after the input pulse sample.
- R8: When an input pulse is missing, the counter keeps running and `fp_out` still pulses once every 512 clocks.
- R9: When the detected style changes, the idle level and pulse polarity of `fp_out` follow in the clock after the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4.096 MHz bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fp_in | input | 1 | Incoming frame pulse, either style |
| slot_o | output | 5 | Current channel count |
| bit_o | output | 3 | Current bit count within the channel |
| fp_out | output | 1 | Outgoing frame pulse in the opposite style |

## Verification
An input pulse sampled on clock edge E shows up in the counts in the very next cycle: channel 0 or channel 5, bit 0. The converted pulse is registered from the next position, so it appears in the cycle where the position is 79 (80 clocks after E) or 511 (431 clocks after the reload to 80). A change of style decided on edge D shows on `fp_out` only from edge D+1. The bench counts edges since reset and files each expectation under the exact edge index where these delays place it. All outputs are sampled on the falling clock edge, and the input is changed on that same falling edge, so the next rising edge samples it.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    // Style of the incoming frame pulse.
    typedef enum logic {
        FMT_IDLE_HIGH = 1'b0,  // pulse low, straddles the frame boundary
        FMT_IDLE_LOW  = 1'b1   // pulse high, at the start of channel 5
    } fp_fmt_e;

    // Level that marks a pulse for a given input style.
    function automatic logic active_level(input fp_fmt_e fmt);
        return (fmt == FMT_IDLE_LOW);
    endfunction

endpackage

// File: rtl/fpc_idle_detect.sv
module fpc_idle_detect
    import fpc_pkg::*;
#(
    parameter int IDLE_RUN = 5
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    fp_in,
    output fp_fmt_e fmt_o,
    output logic    locked_o,
    output logic    hit_o
);
    localparam int RUN_W = $clog2(IDLE_RUN + 1);

    typedef struct packed {
        logic             prev;
        logic [RUN_W-1:0] run;
        logic             locked;
        fp_fmt_e          fmt;
    } det_t;

    det_t st_d, st_q;
    logic hit_d;

    always_comb begin
        st_d  = st_q;
        hit_d = st_q.locked
             && (fp_in == active_level(st_q.fmt))
             && (st_q.prev != active_level(st_q.fmt));

        if (fp_in != st_q.prev) begin
            st_d.run = RUN_W'(1);
        end else if (st_q.run < RUN_W'(IDLE_RUN)) begin
            st_d.run = st_q.run + RUN_W'(1);
        end

        if (st_d.run == RUN_W'(IDLE_RUN)) begin
            st_d.locked = 1'b1;
            st_d.fmt    = fp_in ? FMT_IDLE_HIGH : FMT_IDLE_LOW;
        end
        st_d.prev = fp_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev: 1'b0, run: '0, locked: 1'b0, fmt: FMT_IDLE_HIGH};
        end else begin
            st_q <= st_d;
        end
    end

    assign fmt_o    = st_q.fmt;
    assign locked_o = st_q.locked;
    assign hit_o    = hit_d;

endmodule

// File: rtl/fpc_frame_counter.sv
module fpc_frame_counter #(
    parameter int FRAME_CLKS = 512,
    parameter int POS_W      = $clog2(FRAME_CLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [POS_W-1:0] load_val_i,
    output logic [POS_W-1:0] pos_o,
    output logic [POS_W-1:0] pos_next_o
);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_CLKS - 1);

    logic [POS_W-1:0] pos_d, pos_q;

    always_comb begin
        if (load_i) begin
            pos_d = load_val_i;
        end else if (pos_q == LAST) begin
            pos_d = '0;
        end else begin
            pos_d = pos_q + POS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign pos_o      = pos_q;
    assign pos_next_o = pos_d;

endmodule

// File: rtl/fpc_pulse_gen.sv
module fpc_pulse_gen
    import fpc_pkg::*;
#(
    parameter int POS_W       = 9,
    parameter int HIGH_TARGET = 79,   // position of a high pulse out
    parameter int LOW_TARGET  = 511   // position of a low pulse out
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fp_fmt_e          fmt_i,
    input  logic [POS_W-1:0] pos_next_i,
    output logic             fp_out_o
);
    logic out_d, out_q;

    always_comb begin
        if (fmt_i == FMT_IDLE_HIGH) begin
            // opposite style: idle low, high for one clock
            out_d = (pos_next_i == POS_W'(HIGH_TARGET));
        end else begin
            // opposite style: idle high, low for one clock
            out_d = (pos_next_i != POS_W'(LOW_TARGET));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign fp_out_o = out_q;

endmodule

// File: rtl/fp_converter.sv
module fp_converter
    import fpc_pkg::*;
#(
    parameter int SLOTS        = 32,
    parameter int SLOT_BITS    = 8,
    parameter int CLKS_PER_BIT = 2,
    parameter int IDLE_RUN     = 5,
    parameter int SHIFT_SLOTS  = 5,
    localparam int SLOT_W      = $clog2(SLOTS),
    localparam int BIT_W       = $clog2(SLOT_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fp_in,
    output logic [SLOT_W-1:0] slot_o,
    output logic [BIT_W-1:0]  bit_o,
    output logic              fp_out
);
    localparam int SLOT_CLKS   = SLOT_BITS * CLKS_PER_BIT;
    localparam int FRAME_CLKS  = SLOTS * SLOT_CLKS;
    localparam int POS_W       = $clog2(FRAME_CLKS);
    localparam int PHASE_W     = $clog2(CLKS_PER_BIT);
    localparam int HIGH_PRESET = SHIFT_SLOTS * SLOT_CLKS;

    fp_fmt_e          fmt;
    logic             locked;
    logic             hit;
    logic [POS_W-1:0] pos, pos_next, load_val;

    fpc_idle_detect #(.IDLE_RUN(IDLE_RUN)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .fp_in    (fp_in),
        .fmt_o    (fmt),
        .locked_o (locked),
        .hit_o    (hit)
    );

    assign load_val = (fmt == FMT_IDLE_LOW) ? POS_W'(HIGH_PRESET) : '0;

    fpc_frame_counter #(.FRAME_CLKS(FRAME_CLKS), .POS_W(POS_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (hit),
        .load_val_i (load_val),
        .pos_o      (pos),
        .pos_next_o (pos_next)
    );

    fpc_pulse_gen #(
        .POS_W       (POS_W),
        .HIGH_TARGET (HIGH_PRESET - 1),
        .LOW_TARGET  (FRAME_CLKS - 1)
    ) u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_i      (fmt),
        .pos_next_i (pos_next),
        .fp_out_o   (fp_out)
    );

    assign slot_o = pos[POS_W-1 -: SLOT_W];
    assign bit_o  = pos[PHASE_W +: BIT_W];

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
    parameter int POS_W       = 9,
    parameter int FRAME_CLKS  = 512,
    parameter int HIGH_PRESET = 80
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit,
    input logic             locked,
    input logic             fmt,
    input logic [POS_W-1:0] pos,
    input logic             fp_out
);
    logic fmt_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fmt_prev_q <= 1'b0;
        else        fmt_prev_q <= fmt;
    end

    assert_free_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> pos == (($past(pos) == POS_W'(FRAME_CLKS - 1)) ? '0
                                                               : $past(pos) + POS_W'(1)));

    assert_lock_before_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> locked);

    assert_load_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !fmt) |=> pos == '0);

    assert_load_five_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && fmt) |=> pos == POS_W'(HIGH_PRESET));

    assert_high_out_place_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_out && !fmt_prev_q) |-> pos == POS_W'(HIGH_PRESET - 1));

    assert_low_out_place_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fp_out && fmt_prev_q) |-> pos == POS_W'(FRAME_CLKS - 1));

endmodule

bind fp_converter fpc_checker #(
    .POS_W       (POS_W),
    .FRAME_CLKS  (FRAME_CLKS),
    .HIGH_PRESET (HIGH_PRESET)
) u_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit),
    .locked (locked),
    .fmt    (fmt),
    .pos    (pos),
    .fp_out (fp_out)
);

// File: tb/fp_converter_tb_top.sv
`timescale 1ns/1ps
module fp_converter_tb_top;

    typedef struct {
        int         at;
        logic [4:0] slot;
        logic [2:0] bitc;
        logic       chk_pos;
        logic       fpo;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fp_in = 1'b1;
    logic [4:0] slot_o;
    logic [2:0] bit_o;
    logic fp_out;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    fp_converter dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .fp_in  (fp_in),
        .slot_o (slot_o),
        .bit_o  (bit_o),
        .fp_out (fp_out)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // driver side: expectations are queued in ascending edge order
    task automatic expect_at(input int at, input int slot, input int bitc,
                             input logic chk_pos, input logic fpo, input string tag);
        exp_t e;
        e.at = at; e.slot = 5'(slot); e.bitc = 3'(bitc);
        e.chk_pos = chk_pos; e.fpo = fpo; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc != n) @(negedge clk);
    endtask

    // monitor: pops and compares at the falling edge after the due rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                n_run++;
                if (e.at != cyc) begin
                    n_fail++;
                    $display("FAIL %s edge %0d missed: actual edge=%0d expected edge=%0d",
                             e.tag, e.at, cyc, e.at);
                end else if (fp_out !== e.fpo ||
                             (e.chk_pos && (slot_o !== e.slot || bit_o !== e.bitc))) begin
                    n_fail++;
                    $display("FAIL %s edge %0d: actual slot=%0d bit=%0d fp_out=%b expected slot=%0d bit=%0d fp_out=%b",
                             e.tag, cyc, slot_o, bit_o, fp_out, e.slot, e.bitc, e.fpo);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1..: actual=hung expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        expect_at(0,    0,  0, 1, 0, "R1");
        // R3 a low sample before the first decision does not reload
        expect_at(37,   2,  2, 1, 0, "R3");
        // R6 converted pulse high for one clock at position 79
        expect_at(78,   4,  7, 1, 0, "R6");
        expect_at(79,   4,  7, 1, 1, "R6");
        expect_at(80,   5,  0, 1, 0, "R6");
        // R2 wrap from 511 to 0
        expect_at(511, 31,  7, 1, 0, "R2");
        expect_at(512,  0,  0, 1, 0, "R2");
        // R8 no input pulse, output still pulses
        expect_at(591,  4,  7, 1, 1, "R8");
        expect_at(600,  5,  4, 1, 0, "R2");
        // R4 idle-high style pulse reloads to 0
        expect_at(601,  0,  0, 1, 0, "R4");
        expect_at(679,  0,  0, 0, 0, "R6");
        expect_at(680,  4,  7, 1, 1, "R6");
        expect_at(681,  0,  0, 0, 0, "R6");
        expect_at(700,  6,  1, 1, 0, "R4");
        expect_at(701,  0,  0, 1, 0, "R4");
        // R9 style switch: output idle follows one clock after decision at 705
        expect_at(705,  0,  0, 0, 0, "R9");
        expect_at(706,  0,  0, 0, 1, "R9");
        expect_at(710,  0,  9, 0, 1, "R3");
        // R5 idle-low style pulse reloads to 80
        expect_at(800,  6,  1, 1, 1, "R5");
        expect_at(801,  5,  0, 1, 1, "R5");
        // R7 converted pulse low for one clock at position 511
        expect_at(1231, 0,  0, 0, 1, "R7");
        expect_at(1232, 31, 7, 1, 0, "R7");
        expect_at(1233, 0,  0, 1, 1, "R7");
        // R8 next frame without input pulse
        expect_at(1744, 31, 7, 1, 0, "R8");
        expect_at(1745, 0,  0, 1, 1, "R8");

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        wait_cyc(2);   fp_in = 1'b0;
        wait_cyc(3);   fp_in = 1'b1;
        wait_cyc(600); fp_in = 1'b0;
        wait_cyc(601); fp_in = 1'b1;
        wait_cyc(700); fp_in = 1'b0;
        wait_cyc(800); fp_in = 1'b1;
        wait_cyc(801); fp_in = 1'b0;
        wait_cyc(1760);

        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            n_fail++;
            $display("FAIL %s edge %0d never checked: actual=pending expected=checked", e.tag, e.at);
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule